// File: doc/BRIEF.md
# Envelope Feature Tap Generator

This block conditions complex baseband samples for an augmented time-delay predistortion network. Each accepted sample, given as signed fixed-point in-phase (I) and quadrature (Q) words, is expanded into five features: the raw I, the raw Q, the envelope magnitude, the squared magnitude and the cubed magnitude. The envelope terms hand the downstream network explicit amplitude information, so it does not have to derive that information from I and Q itself.

The five features of the newest sample and of the previous MEM accepted samples are held in a tap line. The whole tap line is presented as one registered parallel vector of 5·(MEM+1) words. A plain I/Q tap line would present only 2·(MEM+1) words.

Inputs are treated as Q1.(DW-1) numbers, and all envelope outputs are unsigned words in the same scale. The power is computed exactly. The magnitude comes from a fully pipelined bit-serial integer square root. The cube is the magnitude times the power. Pipeline registers carry I and Q alongside the root so that every feature of one sample reaches the tap line in the same cycle.

Top module: `envtap_gen`

## Requirements
- R1: `out_feat` holds MEM+1 groups of five DW-bit words. Group d (d=0 is the newest accepted sample, d=MEM the oldest) starts at word 5·d. Within a group, word 0 is I and word 1 is Q, both passed through unchanged. Word 2 is the magnitude, word 3 the power and word 4 the cube.
- R2: With P = I²+Q² computed exactly, the power word is min(P >> (DW-1), 2^DW−1).
- R3: The magnitude word is floor(sqrt(P)).
- R4: The cube word is min((magnitude·P) >> 2(DW-1), 2^DW−1).
- R5: The features of a sample accepted at clock edge k appear in group 0 after edge k+DW+2. All five words of that sample appear in the same cycle.
- R6: The tap line shifts only for samples presented with `in_valid` high. When no sample arrives, `out_feat` holds its value.
- R7: `out_valid` is high for exactly one cycle per accepted sample, in the cycle that sample enters group 0. It stays low until MEM+1 samples have been accepted since reset.
- R8: While `rst_n` is low at a clock edge, all taps are cleared to zero, `out_valid` is driven low, and the count of accepted samples restarts. Samples already in the pipeline are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The sample on `in_i`/`in_q` is accepted at this edge |
| in_i | input | DW | Signed in-phase sample |
| in_q | input | DW | Signed quadrature sample |
| out_valid | output | 1 | One-cycle strobe: new full feature vector |
| out_feat | output | 5·(MEM+1)·DW | Parallel feature vector, laid out as in R1 |

## Verification
Every sample lands in group 0 exactly DW+2 edges (18 with the defaults) after the edge that accepts it. The other groups move one place each time a later sample is accepted. The bench drives inputs on the falling edge and schedules each accepted sample's expected vector into a ring of future slots, 18 edges ahead. At each following falling edge it compares `out_valid` and every word against the slot for that cycle. In a cycle with no scheduled shift, it requires the vector to equal the last expected vector. Saturating, zero and full-scale corner inputs are mixed into seeded random traffic that has random gaps. A reset in the middle of the run checks that in-flight samples are discarded and that the fill count restarts.

// File: rtl/envtap_pkg.sv
// Package envtap_pkg
// Shared constants for the envelope feature tap generator: feature slot
// order inside one tap group. The slot order is part of the output contract.
package envtap_pkg;

    typedef enum int {
        FLD_I    = 0,
        FLD_Q    = 1,
        FLD_MAG  = 2,
        FLD_POW  = 3,
        FLD_CUBE = 4
    } feat_field_e;

    localparam int NFIELD = 5;

endpackage

// File: rtl/envtap_power.sv
// Module envtap_power
// Registers an accepted I/Q sample together with its exact power I^2+Q^2.
// Assumes signed two's-complement inputs; the power fits in 2*DW unsigned bits.
module envtap_power #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [DW-1:0] i_i,
    input  logic signed [DW-1:0] q_i,
    output logic                 v_o,
    output logic [2*DW-1:0]      p_o,
    output logic [2*DW-1:0]      iq_o
);

    logic signed [2*DW-1:0] sq_i;
    logic signed [2*DW-1:0] sq_q;

    // Exact signed squares of each component.
    always_comb begin
        sq_i = i_i * i_i;
        sq_q = q_i * q_i;
    end

    // Capture stage: sample, raw words and power.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o  <= 1'b0;
            p_o  <= '0;
            iq_o <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                p_o  <= $unsigned(sq_i) + $unsigned(sq_q);
                iq_o <= {q_i, i_i};
            end
        end
    end

endmodule

// File: rtl/envtap_sqrt_stage.sv
// Module envtap_sqrt_stage
// One bit of a pipelined integer square root. It decides result bit BIT by
// testing whether (root + 2^BIT)^2 still fits under the radicand. It keeps a
// running root^2 so that no multiplier is needed. The radicand and the raw
// I/Q word travel along unchanged.
module envtap_sqrt_stage #(
    parameter int DW  = 16,
    parameter int BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            v_i,
    input  logic [2*DW-1:0] p_i,
    input  logic [DW-1:0]   root_i,
    input  logic [2*DW-1:0] sq_i,
    input  logic [2*DW-1:0] iq_i,
    output logic            v_o,
    output logic [2*DW-1:0] p_o,
    output logic [DW-1:0]   root_o,
    output logic [2*DW-1:0] sq_o,
    output logic [2*DW-1:0] iq_o
);

    localparam int W2 = 2 * DW + 2;

    logic [W2-1:0] trial;
    logic          take;

    // Square of the candidate root: root^2 + 2*root*2^BIT + 2^(2*BIT).
    always_comb begin
        trial = W2'(sq_i) + (W2'(root_i) << (BIT + 1)) + (W2'(1) << (2 * BIT));
        take  = (trial <= W2'(p_i));
    end

    // Pipeline register for this bit decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            p_o    <= '0;
            root_o <= '0;
            sq_o   <= '0;
            iq_o   <= '0;
        end else begin
            v_o    <= v_i;
            p_o    <= p_i;
            iq_o   <= iq_i;
            root_o <= take ? (root_i | (DW'(1) << BIT)) : root_i;
            sq_o   <= take ? trial[2*DW-1:0] : sq_i;
        end
    end

endmodule

// File: rtl/envtap_cube.sv
// Module envtap_cube
// Scales the power and the cube back to Q1.(DW-1) and saturates both to
// DW unsigned bits. Assumes the magnitude input is floor(sqrt(power)).
module envtap_cube #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            v_i,
    input  logic [2*DW-1:0] p_i,
    input  logic [DW-1:0]   mag_i,
    input  logic [2*DW-1:0] iq_i,
    output logic            v_o,
    output logic [2*DW-1:0] iq_o,
    output logic [DW-1:0]   mag_o,
    output logic [DW-1:0]   pow_o,
    output logic [DW-1:0]   cube_o
);

    localparam int FRAC = DW - 1;
    localparam logic [2*DW-1:0] POW_MAX  = {{DW{1'b0}}, {DW{1'b1}}};
    localparam logic [3*DW-1:0] CUBE_MAX = {{2*DW{1'b0}}, {DW{1'b1}}};
    localparam logic [DW-1:0]   ONE      = DW'(1) << FRAC;

    logic [2*DW-1:0] pow_full;
    logic [3*DW-1:0] prod;
    logic [3*DW-1:0] cube_full;

    // Rescale power and magnitude*power to the output fraction width.
    always_comb begin
        pow_full  = p_i >> FRAC;
        prod      = (3*DW)'(mag_i) * (3*DW)'(p_i);
        cube_full = prod >> (2 * FRAC);
    end

    // Output register with saturation of both envelope powers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            iq_o   <= '0;
            mag_o  <= '0;
            pow_o  <= '0;
            cube_o <= '0;
        end else begin
            v_o    <= v_i;
            iq_o   <= iq_i;
            mag_o  <= mag_i;
            pow_o  <= (pow_full > POW_MAX) ? {DW{1'b1}} : pow_full[DW-1:0];
            cube_o <= (cube_full > CUBE_MAX) ? {DW{1'b1}} : cube_full[DW-1:0];
        end
    end

    // R2: a magnitude of at least 1.0 implies a power of at least 1.0.
    a_r2_pow_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (v_o && mag_o >= ONE) |-> (pow_o >= ONE));

    // R4: for a magnitude of at least 1.0, the cube is never below the power.
    a_r4_cube_ge_pow: assert property (@(posedge clk) disable iff (!rst_n)
        (v_o && mag_o >= ONE) |-> (cube_o >= pow_o));

endmodule

// File: rtl/envtap_tapline.sv
// Module envtap_tapline
// Holds MEM+1 groups of five features and shifts on each valid input. It
// raises a one-cycle valid once the line has been filled since reset.
module envtap_tapline
    import envtap_pkg::*;
#(
    parameter int DW  = 16,
    parameter int MEM = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         v_i,
    input  logic [2*DW-1:0]              iq_i,
    input  logic [DW-1:0]                mag_i,
    input  logic [DW-1:0]                pow_i,
    input  logic [DW-1:0]                cube_i,
    output logic                         out_valid,
    output logic [NFIELD*(MEM+1)*DW-1:0] out_feat
);

    localparam int GW = NFIELD * DW;
    localparam int CW = $clog2(MEM + 2);

    logic [GW-1:0] tap [0:MEM];
    logic [GW-1:0] grp;
    logic [CW-1:0] fill;

    // Pack one group in field order I, Q, magnitude, power, cube.
    always_comb begin
        grp = '0;
        grp[FLD_I*DW    +: DW] = iq_i[DW-1:0];
        grp[FLD_Q*DW    +: DW] = iq_i[2*DW-1:DW];
        grp[FLD_MAG*DW  +: DW] = mag_i;
        grp[FLD_POW*DW  +: DW] = pow_i;
        grp[FLD_CUBE*DW +: DW] = cube_i;
    end

    // Newest tap loads the fresh group on a valid input.
    always_ff @(posedge clk) begin
        if (!rst_n)   tap[0] <= '0;
        else if (v_i) tap[0] <= grp;
    end

    genvar d;
    generate
        for (d = 1; d <= MEM; d++) begin : g_shift
            // Older taps move one place on each valid input.
            always_ff @(posedge clk) begin
                if (!rst_n)   tap[d] <= '0;
                else if (v_i) tap[d] <= tap[d-1];
            end
        end
        for (d = 0; d <= MEM; d++) begin : g_out
            assign out_feat[d*GW +: GW] = tap[d];
        end
    endgenerate

    // Fill count and output strobe once MEM+1 samples are present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= v_i && (fill == CW'(MEM));
            if (v_i && fill != CW'(MEM)) fill <= fill + 1'b1;
        end
    end

    // R6: without a valid input the whole vector is held.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !v_i |=> $stable(out_feat));

    // R7: a strobe always follows an input that shifted the line.
    a_r7_strobe_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(v_i));

    // R8: reset leaves a cleared, not-valid vector.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_feat == '0));

endmodule

// File: rtl/envtap_gen.sv
// Module envtap_gen
// Top of the envelope feature tap generator. The stages are the power
// capture, DW square-root bit stages, the cube/saturation stage and the tap
// line. The latency from the accepting edge to the tap line is DW+2 edges.
// Assumes Q1.(DW-1) signed inputs.
module envtap_gen
    import envtap_pkg::*;
#(
    parameter int DW  = 16,
    parameter int MEM = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic signed [DW-1:0]         in_i,
    input  logic signed [DW-1:0]         in_q,
    output logic                         out_valid,
    output logic [NFIELD*(MEM+1)*DW-1:0] out_feat
);

    localparam int W2 = 2 * DW + 2;

    logic            ch_v    [0:DW];
    logic [2*DW-1:0] ch_p    [0:DW];
    logic [DW-1:0]   ch_root [0:DW];
    logic [2*DW-1:0] ch_sq   [0:DW];
    logic [2*DW-1:0] ch_iq   [0:DW];

    logic            cb_v;
    logic [2*DW-1:0] cb_iq;
    logic [DW-1:0]   cb_mag;
    logic [DW-1:0]   cb_pow;
    logic [DW-1:0]   cb_cube;

    envtap_power #(.DW(DW)) u_power (
        .clk  (clk),
        .rst_n(rst_n),
        .v_i  (in_valid),
        .i_i  (in_i),
        .q_i  (in_q),
        .v_o  (ch_v[0]),
        .p_o  (ch_p[0]),
        .iq_o (ch_iq[0])
    );

    assign ch_root[0] = '0;
    assign ch_sq[0]   = '0;

    genvar j;
    generate
        for (j = 0; j < DW; j++) begin : g_sqrt
            envtap_sqrt_stage #(.DW(DW), .BIT(DW - 1 - j)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .v_i   (ch_v[j]),
                .p_i   (ch_p[j]),
                .root_i(ch_root[j]),
                .sq_i  (ch_sq[j]),
                .iq_i  (ch_iq[j]),
                .v_o   (ch_v[j+1]),
                .p_o   (ch_p[j+1]),
                .root_o(ch_root[j+1]),
                .sq_o  (ch_sq[j+1]),
                .iq_o  (ch_iq[j+1])
            );
        end
    endgenerate

    envtap_cube #(.DW(DW)) u_cube (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (ch_v[DW]),
        .p_i   (ch_p[DW]),
        .mag_i (ch_root[DW]),
        .iq_i  (ch_iq[DW]),
        .v_o   (cb_v),
        .iq_o  (cb_iq),
        .mag_o (cb_mag),
        .pow_o (cb_pow),
        .cube_o(cb_cube)
    );

    envtap_tapline #(.DW(DW), .MEM(MEM)) u_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_i      (cb_v),
        .iq_i     (cb_iq),
        .mag_i    (cb_mag),
        .pow_i    (cb_pow),
        .cube_i   (cb_cube),
        .out_valid(out_valid),
        .out_feat (out_feat)
    );

    // R3: the finished root is the floor of the square root of the power.
    a_r3_root_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ch_v[DW] |->
            ((W2'(ch_root[DW]) * W2'(ch_root[DW]) <= W2'(ch_p[DW])) &&
             ((W2'(ch_root[DW]) + 1) * (W2'(ch_root[DW]) + 1) > W2'(ch_p[DW]))));

endmodule

// File: tb/envtap_gen_bench.sv
// Bench for envtap_gen: directed corner samples followed by seeded random
// traffic with gaps, a reset in mid-run, and cycle-exact expected vectors.
module envtap_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int MEM  = 2;
    localparam int TAPS = MEM + 1;
    localparam int NF   = 5;
    localparam int VW   = NF * TAPS * DW;
    localparam int LAT  = DW + 2;
    localparam int RING = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic                 out_valid;
    logic [VW-1:0]        out_feat;

    envtap_gen #(.DW(DW), .MEM(MEM)) u_envtap_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .out_valid(out_valid),
        .out_feat (out_feat)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int unsigned cyc = 0;
    always_ff @(posedge clk) cyc <= cyc + 1;

    int n_chk  = 0;
    int n_fail = 0;
    int acc    = 0;
    logic [VW-1:0] e_vec   [0:RING-1];
    logic          e_shift [0:RING-1];
    logic          e_valid [0:RING-1];
    logic [VW-1:0] cur_exp = '0;
    logic [NF*DW-1:0] hist [0:MEM];

    function automatic longint isqrt_ref(longint p);
        longint r = 0;
        for (int b = DW - 1; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= p) r = t;
        end
        return r;
    endfunction

    function automatic logic [NF*DW-1:0] group_ref(int si, int sq);
        longint p   = longint'(si) * si + longint'(sq) * sq;
        longint mag = isqrt_ref(p);
        longint pw  = p >> (DW - 1);
        longint cb  = (mag * p) >> (2 * (DW - 1));
        logic [NF*DW-1:0] g;
        if (pw > 65535) pw = 65535;
        if (cb > 65535) cb = 65535;
        g = '0;
        g[0*DW +: DW] = DW'(si);
        g[1*DW +: DW] = DW'(sq);
        g[2*DW +: DW] = DW'(mag);
        g[3*DW +: DW] = DW'(pw);
        g[4*DW +: DW] = DW'(cb);
        return g;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < RING; s++) begin
            e_vec[s] = '0; e_shift[s] = 1'b0; e_valid[s] = 1'b0;
        end
        for (int d = 0; d <= MEM; d++) hist[d] = '0;
        cur_exp = '0;
        acc = 0;
    endtask

    // Compare outputs against the slot due this cycle (R5 timing).
    task automatic check_cycle();
        int s = int'(cyc % RING);
        chk(out_valid == e_valid[s], "R7 valid strobe", longint'(out_valid), longint'(e_valid[s]));
        if (e_shift[s]) begin
            cur_exp = e_vec[s];
            for (int d = 0; d < TAPS; d++) begin
                for (int f = 0; f < NF; f++) begin
                    longint a = longint'(out_feat[(d*NF+f)*DW +: DW]);
                    longint e = longint'(cur_exp[(d*NF+f)*DW +: DW]);
                    string tag;
                    case (f)
                        0, 1:    tag = "R1 raw tap (R5 timing)";
                        2:       tag = "R3 magnitude (R5 timing)";
                        3:       tag = "R2 power (R5 timing)";
                        default: tag = "R4 cube (R5 timing)";
                    endcase
                    chk(a == e, tag, a, e);
                end
            end
        end else begin
            n_chk++;
            if (out_feat !== cur_exp) begin
                n_fail++;
                $display("FAIL R6 hold at cycle %0d: actual %h expected %h", cyc, out_feat, cur_exp);
            end
        end
        e_shift[s] = 1'b0;
        e_valid[s] = 1'b0;
    endtask

    // One falling-edge step: check, then drive the next sample.
    task automatic step(input bit v, input int si, input int sq);
        @(negedge clk);
        check_cycle();
        in_valid = v;
        in_i = DW'(si);
        in_q = DW'(sq);
        if (v) begin
            int s = int'((cyc + 1 + LAT) % RING);
            logic [VW-1:0] vec;
            for (int d = MEM; d > 0; d--) hist[d] = hist[d-1];
            hist[0] = group_ref(si, sq);
            acc++;
            for (int d = 0; d <= MEM; d++) vec[d*NF*DW +: NF*DW] = hist[d];
            e_vec[s]   = vec;
            e_shift[s] = 1'b1;
            e_valid[s] = (acc >= TAPS);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        // R8: cleared vector and no strobe right after reset.
        chk(out_valid == 1'b0, "R8 valid after reset", longint'(out_valid), 0);
        n_chk++;
        if (out_feat !== '0) begin
            n_fail++;
            $display("FAIL R8 taps after reset: actual %h expected 0", out_feat);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd24680));
        model_clear();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state.
        chk(out_valid == 1'b0, "R8 valid at start", longint'(out_valid), 0);
        chk(out_feat == '0, "R8 taps at start", longint'(out_feat[31:0]), 0);

        // Directed corners: zero, full scale, saturating power/cube (R2, R4).
        step(1, 0, 0);
        step(1, 32767, 0);
        step(0, 0, 0);
        step(1, -32768, -32768);
        step(1, -32768, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        step(1, 0, -32767);
        step(1, 1, 1);
        step(1, 23170, 23170);
        step(1, -1, 0);
        step(1, 23171, 23171);
        for (int k = 0; k < LAT + 4; k++) step(0, 0, 0);

        // Seeded random traffic with gaps.
        for (int k = 0; k < 800; k++) begin
            bit v = ($urandom % 10) < 7;
            step(v, int'($signed(16'($urandom))), int'($signed(16'($urandom))));
        end
        for (int k = 0; k < LAT + 2; k++) step(0, 0, 0);

        // Mid-run reset with samples in flight; fill count restarts (R7, R8).
        step(1, 1000, -2000);
        step(1, -3000, 4000);
        do_reset();
        step(1, 12345, -54);
        step(0, 0, 0);
        step(1, -32768, 32767);
        for (int k = 0; k < LAT + 3; k++) step(0, 0, 0);
        step(1, 7, -7);
        for (int k = 0; k < 40; k++) begin
            step(1, int'($signed(16'($urandom))), int'($signed(16'($urandom))));
        end
        for (int k = 0; k < LAT + 3; k++) step(0, 0, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule